// File: doc/BRIEF.md
# Latched-Status Interrupt Aggregator with Pending Replay

This block gathers many level-sensitive interrupt sources into a small set of output interrupt lines. The sources are organised in groups. Each group owns a fixed number of source lines and drives exactly one output line. Software sees two words per group on a simple 32-bit register bus.

The first word is an enable word. Writes to it do one of two jobs. A write that adds new bits grows a sticky accumulated enable vector. Any other write toggles an in-service mask. The second word is a status word that latches which enabled sources fired. Software acknowledges a source by writing ones to its status bits.

Sources that fire while the group is busy are collected in a hidden pending vector. A group counts as busy when its status is non-zero or a mask bit is set. Once every status bit has been acknowledged, the whole pending vector is moved into status in a single step. The output stays asserted through that step.

Each group runs a two-state machine. The states are `G_QUIET`, with the output low, and `G_RAISED`, with the output high.
- **LATCH** (`G_QUIET` to `G_RAISED`): a source evaluation loads status.
- **REPLAY** (`G_QUIET` to `G_RAISED`, or staying in `G_RAISED`): a completing clear copies pending into status.
- **DROP** (`G_RAISED` to `G_QUIET`): a completing clear finds pending empty and no new latch occurs in the same cycle.
- **HOLD** (no change): any other cycle, including an all-ones initialisation clear.

Top module: `irq_latch_agg`

## Requirements
- R1: Reset behaviour.
  - After reset every enable word, status word, accumulated enable, mask and pending vector is zero.
  - Every output line is low.
- R2: Address map and reads.
  - Group n's enable word is at byte address 0x1000 + n*0x100, and its status word is at 0x1004 + n*0x100.
  - A read returns the addressed word on `bus_rdata` in the cycle after the request.
  - Any other address reads as zero, and a write to it changes no group.
- R3: Source evaluation.
  - A group evaluates its sources in a cycle where at least one of its source lines is high while its registered copy from the previous cycle was low.
  - The selected set is every currently high line ANDed with the accumulated enable.
  - An empty selected set changes nothing.
- R4: Latching into status. When the selected set is non-empty and both the group's status and its mask are zero, status is loaded with the selected set and the output goes high after that clock edge.
- R5: Collecting into pending. When the selected set is non-empty and either status or mask is non-zero, the set is ORed into pending. Status and the output are left unchanged.
- R6: Sticky enable and read-back.
  - An enable write ORs the written value into the accumulated enable, so writes never clear enable bits.
  - The enable word reads back the last written value, not the accumulated enable.
- R7: Zero write to an idle enable. Writing zero to an enable word while the accumulated enable is zero only stores the zero.
- R8: Mask and unmask.
  - This rule applies to an enable write that leaves the accumulated enable unchanged. Let change = old enable word XOR written value.
  - If change AND written value is non-zero, the change bits are cleared in the mask.
  - Otherwise the change bits are set in the mask.
- R9: Status clearing.
  - A status write clears the written one-bits in status.
  - A status write of zero is ignored.
- R10: Initialisation clear. A status write of 0xFFFFFFFF clears status without replaying pending and without changing the output.
- R11: Completing clear. This rule applies to a clear by any other non-zero value that leaves status zero.
  - If pending is non-zero, status is loaded from pending, pending is cleared, and the output is high.
  - If pending is zero, the output goes low.
- R12: Same-cycle ordering.
  - This rule applies when a status write and a source evaluation hit the same group in one cycle.
  - The clear, together with any replay or drop, is applied first.
  - The evaluation then sees the updated status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| src_lines | input | 288 | Source lines; group n uses bits [n*32 +: 32] |
| irq_out | output | 9 | Output line per group |

## Verification
The hardest case to reach from the ports is a REPLAY that raises a quiet output. Pending must fill while status is zero, which only happens behind a mask bit. That mask bit must be set by an enable write that leaves the accumulated enable unchanged, and then cleared by a second such write. The stimulus walks through that exact sequence: it sets the mask, raises a masked source, unmasks, and then performs a completing clear on an already empty status.

The bench also lines up a status clear and a rising source edge on the same clock edge. This shows that the clear is applied first and that the evaluation then latches every enabled high line.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    typedef enum logic {
        G_QUIET  = 1'b0,
        G_RAISED = 1'b1
    } grp_state_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec #(
    parameter int ADDR_W    = 16,
    parameter int BASE      = 'h1000,
    parameter int STRIDE_LG = 8,
    parameter int NUM_GROUPS = 9,
    localparam int GW       = $clog2(NUM_GROUPS),
    localparam int HI_W     = ADDR_W - STRIDE_LG
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              is_en,
    output logic [GW-1:0]     grp
);
    localparam logic [ADDR_W-1:0]    BASE_W = ADDR_W'(BASE);
    localparam logic [HI_W-1:0]      NG_W   = HI_W'(NUM_GROUPS);
    localparam logic [STRIDE_LG-1:0] ST_OFS = STRIDE_LG'(4);

    logic [ADDR_W-1:0]    off;
    logic [HI_W-1:0]      hi;
    logic [STRIDE_LG-1:0] sub;

    always_comb begin
        off   = addr - BASE_W;
        hi    = off[ADDR_W-1:STRIDE_LG];
        sub   = off[STRIDE_LG-1:0];
        hit   = (addr >= BASE_W) && (hi < NG_W) &&
                ((sub == '0) || (sub == ST_OFS));
        is_en = (sub == '0);
        grp   = hi[GW-1:0];
    end
endmodule

// File: rtl/irq_group.sv
module irq_group
    import irq_agg_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] src_i,
    input  logic             en_wr,
    input  logic             st_wr,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] en_word_o,
    output logic [LINES-1:0] status_o,
    output logic             irq_o
);
    grp_state_e       state_q, state_n;
    logic [LINES-1:0] src_q;
    logic [LINES-1:0] enreg_q, enreg_n;
    logic [LINES-1:0] acc_q, acc_n;
    logic [LINES-1:0] mask_q, mask_n;
    logic [LINES-1:0] pend_q, pend_n;
    logic [LINES-1:0] stat_q, stat_n;
    logic [LINES-1:0] chg, sel;
    logic             edge_seen, fire, do_latch, do_replay, do_drop;

    // enable / mask write decoding
    always_comb begin
        acc_n   = acc_q;
        mask_n  = mask_q;
        enreg_n = enreg_q;
        chg     = enreg_q ^ wdata;
        if (en_wr) begin
            enreg_n = wdata;
            if ((wdata != '0) || (acc_q != '0)) begin
                acc_n = acc_q | wdata;
                if (acc_n == acc_q) begin
                    if ((chg & wdata) != '0) mask_n = mask_q & ~chg;
                    else                     mask_n = mask_q | chg;
                end
            end
        end
    end

    // status clear first, then source evaluation
    always_comb begin
        stat_n    = stat_q;
        pend_n    = pend_q;
        do_replay = 1'b0;
        do_drop   = 1'b0;
        do_latch  = 1'b0;
        if (st_wr && (wdata != '0)) begin
            stat_n = stat_q & ~wdata;
            if ((wdata != '1) && (stat_n == '0)) begin
                if (pend_q != '0) begin
                    stat_n    = pend_q;
                    pend_n    = '0;
                    do_replay = 1'b1;
                end else begin
                    do_drop = 1'b1;
                end
            end
        end
        edge_seen = |(src_i & ~src_q);
        sel       = src_i & acc_q;
        fire      = edge_seen && (sel != '0);
        if (fire) begin
            if ((mask_q != '0) || (stat_n != '0)) begin
                pend_n = pend_n | sel;
            end else begin
                stat_n   = sel;
                do_latch = 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            G_QUIET:  if (do_latch || do_replay) state_n = G_RAISED;
            G_RAISED: if (do_drop && !do_latch)  state_n = G_QUIET;
            default:  state_n = G_QUIET;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= G_QUIET;
        else        state_q <= state_n;
    end

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= '0;
            enreg_q <= '0;
            acc_q   <= '0;
            mask_q  <= '0;
            pend_q  <= '0;
            stat_q  <= '0;
        end else begin
            src_q   <= src_i;
            enreg_q <= enreg_n;
            acc_q   <= acc_n;
            mask_q  <= mask_n;
            pend_q  <= pend_n;
            stat_q  <= stat_n;
        end
    end

    // outputs
    always_comb begin
        irq_o     = (state_q == G_RAISED);
        en_word_o = enreg_q;
        status_o  = stat_q;
    end

    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (stat_q != '0));

    // R11
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> (stat_q == '0 && pend_q == '0));

    // R6
    en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q != '0) |=> ((acc_q & $past(acc_q)) == $past(acc_q)));

    // R9
    stat_zero_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && wdata == '0 && !fire) |=> (stat_q == $past(stat_q)));
endmodule

// File: rtl/irq_latch_agg.sv
module irq_latch_agg #(
    parameter int NUM_GROUPS = 9,
    parameter int LINES      = 32,
    parameter int ADDR_W     = 16,
    parameter int BASE       = 'h1000,
    parameter int STRIDE_LG  = 8,
    localparam int GW        = $clog2(NUM_GROUPS),
    localparam int SRC_W     = NUM_GROUPS * LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [SRC_W-1:0]  src_lines,
    output logic [NUM_GROUPS-1:0] irq_out
);
    logic          hit, is_en;
    logic [GW-1:0] grp;
    logic [LINES-1:0] en_words [NUM_GROUPS];
    logic [LINES-1:0] st_words [NUM_GROUPS];

    irq_addr_dec #(
        .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE_LG(STRIDE_LG), .NUM_GROUPS(NUM_GROUPS)
    ) u_dec (
        .addr(bus_addr), .hit(hit), .is_en(is_en), .grp(grp)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic sel_me;
        assign sel_me = bus_valid && bus_write && hit && (grp == GW'(g));
        irq_group #(.LINES(LINES)) u_grp (
            .clk(clk),
            .rst_n(rst_n),
            .src_i(src_lines[g*LINES +: LINES]),
            .en_wr(sel_me && is_en),
            .st_wr(sel_me && !is_en),
            .wdata(bus_wdata),
            .en_word_o(en_words[g]),
            .status_o(st_words[g]),
            .irq_o(irq_out[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_valid && !bus_write) begin
            if (!hit)       bus_rdata <= '0;
            else if (is_en) bus_rdata <= en_words[grp];
            else            bus_rdata <= st_words[grp];
        end
    end

    // R2
    rd_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !hit) |=> (bus_rdata == '0));
endmodule

// File: tb/tb_irq_latch_agg.sv
module tb_irq_latch_agg;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 9;
    localparam int LN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [15:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NG*LN-1:0] src = '0;
    logic [NG-1:0]   irq_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_pend = 1'b0;
    bit          done = 1'b0;

    irq_latch_agg dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_lines(src), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) rd_pend <= bus_valid & ~bus_write;

    // monitor: compare read data against scoreboard
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s rdata act=%h exp=%h", t, bus_rdata, e);
            end
        end
    end

    function automatic logic [15:0] en_a(int g);
        return 16'(16'h1000 + g * 16'h100);
    endfunction
    function automatic logic [15:0] st_a(int g);
        return 16'(16'h1004 + g * 16'h100);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic [31:0] e, string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_irq(logic [NG-1:0] e, string t);
        checks++;
        if (irq_out !== e) begin
            fails++;
            $display("FAIL %s irq act=%b exp=%b", t, irq_out, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk_irq('0, "R1");
        rd(en_a(0), 32'h0, "R1 en0");
        rd(st_a(0), 32'h0, "R1 st0");

        // R6 enable group 0
        wr(en_a(0), 32'hF);
        rd(en_a(0), 32'hF, "R6 en0");
        // R4 latch
        src[1] = 1'b1; tick();
        chk_irq(9'b000000001, "R4 irq0");
        rd(st_a(0), 32'h2, "R4 st0");
        // R5 pending while status busy; R3 all high lines counted
        src[0] = 1'b1; tick();
        rd(st_a(0), 32'h2, "R5 st0 unchanged");
        // R11 replay
        wr(st_a(0), 32'h2);
        rd(st_a(0), 32'h3, "R11 replay st0");
        chk_irq(9'b000000001, "R11 irq held");
        // R11 drop
        wr(st_a(0), 32'h3);
        chk_irq('0, "R11 drop");
        rd(st_a(0), 32'h0, "R9 st0 cleared");
        // R9 zero write ignored
        src[1:0] = 2'b00; tick();
        src[2] = 1'b1; tick();
        rd(st_a(0), 32'h4, "R4 st0 bit2");
        wr(st_a(0), 32'h0);
        rd(st_a(0), 32'h4, "R9 zero ignored");
        // R10 init clear
        wr(st_a(0), 32'hFFFF_FFFF);
        rd(st_a(0), 32'h0, "R10 st0");
        chk_irq(9'b000000001, "R10 irq unchanged");
        wr(st_a(0), 32'h1);
        chk_irq('0, "R11 empty clear drops");

        // R8 mask then pending behind mask, unmask, replay from quiet
        src[2] = 1'b0; tick();
        wr(en_a(0), 32'h7);
        rd(en_a(0), 32'h7, "R8 en0 readback");
        src[3] = 1'b1; tick();
        rd(st_a(0), 32'h0, "R8 masked st0");
        chk_irq('0, "R8 masked irq");
        wr(en_a(0), 32'hF);
        wr(st_a(0), 32'h1);
        rd(st_a(0), 32'h8, "R8 replay after unmask");
        chk_irq(9'b000000001, "R11 replay raises");

        // R12 clear and edge in same cycle
        src[0] = 1'b1;
        wr(st_a(0), 32'h8);
        rd(st_a(0), 32'h9, "R12 st0");
        chk_irq(9'b000000001, "R12 irq0");

        // R7 and R3 on group 3
        wr(en_a(3), 32'h0);
        rd(en_a(3), 32'h0, "R7 en3");
        src[3*LN+5] = 1'b1; tick();
        rd(st_a(3), 32'h0, "R3 disabled st3");
        chk_irq(9'b000000001, "R3 irq3 low");
        wr(en_a(3), 32'h20);
        src[3*LN+6] = 1'b1; tick();
        rd(st_a(3), 32'h20, "R3 level select st3");
        chk_irq(9'b000001001, "R3 irq3 high");

        // R6 sticky on group 8
        wr(en_a(8), 32'h1);
        wr(en_a(8), 32'h2);
        rd(en_a(8), 32'h2, "R6 en8 last write");
        src[8*LN+0] = 1'b1; tick();
        rd(st_a(8), 32'h1, "R6 sticky st8");
        chk_irq(9'b100001001, "R6 irq8");

        // R2 out of range
        wr(16'h1900, 32'hDEAD_BEEF);
        rd(16'h1900, 32'h0, "R2 out of range");
        rd(16'h1008, 32'h0, "R2 hole");
        rd(st_a(3), 32'h20, "R2 st3 untouched");
        chk_irq(9'b100001001, "R2 irq unchanged");

        tick(); tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule